// File: doc/BRIEF.md
# Strap-addressed SMBus register slave with indexed block access

This block is the management port of a clock-distribution controller. It watches the SMBus clock and data lines through a synchronizer clocked by the system clock. Its 7-bit bus address comes from two three-level strap inputs, and it holds a bank of nine byte-wide registers. These registers carry the per-output enable bits, readbacks of the operating-mode straps, identification bytes and a read-back length register. The enable bits leave the block as a 15-bit vector that gates the clock outputs elsewhere on the chip.

Every transfer names a starting register index. A write then carries a byte count and the data bytes. A read switches direction with a repeated START. The slave first returns the stored read-back length, then register contents from the index upward until the host stops acknowledging.

Top module: `smb_regbank_slave`

## Requirements
- R1: The slave address is decoded from the straps, each coded 2'b00 low, 2'b01 mid and 2'b10 or 2'b11 high. The pair (A1,A0) maps as LL→0x6C, LM→0x6D, LH→0x6F, ML→0x61, MM→0x62, MH→0x63, HL→0x65, HM→0x66, HH→0x67 (7-bit values). An address byte is the 7-bit address followed by a direction bit, with 0 meaning write.
- R2: An address byte that does not match is not acknowledged. The slave then leaves SDA released and ignores all bus traffic until the next START.
- R3: A block write is: address+write, index N, count X, then data bytes. Every byte is acknowledged, and data byte k is written to register N+k.
- R4: Data bytes beyond the first X of a block write are acknowledged but change no register.
- R5: A block read is: address+write, index N, repeated START, address+read. The slave returns the read-back length byte, then registers N, N+1, and so on, one per host ACK, and it releases SDA after a host NACK.
- R6: Register 8 is the read-back length. Bits 4:0 are writable, bits 7:5 read 0, and its reset value is 0x08.
- R7: Register 5 reads {revision, vendor} = 0x11. Register 6 reads 0x99. Registers 3, 4 and 7 read 0x00. Writes to any of these have no effect.
- R8: Register 0 reads {mode strap[1:0], 1, en14, en13, 0, 0, frequency strap}. The two strap fields are captured on the first clock after reset. Bits 4 and 3 are writable and reset to 1.
- R9: Register 1 bits 7,5,4,3,2,1 drive enables 5,4,3,2,1,0. Register 2 bits 7,6,5,3,2,1,0 drive enables 12,11,10,9,8,7,6. These bits reset to 1. The unused bits (register 1 bits 6 and 0, register 2 bit 4) read 1 and cannot be written.
- R10: Indices above 8 read as 0x00, and writes to them are acknowledged but have no effect.
- R11: A STOP, or a START in the middle of a transfer, abandons the transaction. A partly received data byte is not written, and after a START the slave expects an address byte.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_a1_i | input | 2 | Upper address strap level code |
| strap_a0_i | input | 2 | Lower address strap level code |
| pll_mode_i | input | 2 | Operating-mode strap, read back in register 0 |
| freq_sel_i | input | 1 | Frequency-select strap, read back in register 0 |
| out_en_o | output | 15 | Per-output clock enables |

## Verification
The assertions check on every cycle that SDA drive changes only while the synchronized SCL is low, and that the slave never drives SDA while idle. They also check that register writes happen only in the data phase, that the enable vector holds still without a write, and that a START always returns the engine to address reception. Only the bench scenarios can show whether the decoded addresses match the strap table across all nine strap pairs. The same holds for the byte sequences returned by reads, the masking of read-only and reserved bits, the effect of the count limit, and the abandonment of partial bytes.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_IDX, S_CNT, S_WDAT, S_ACK, S_TX, S_MACK
  } link_st_e;

  function automatic logic [1:0] lvl(input logic [1:0] code);
    return code[1] ? 2'd2 : {1'b0, code[0]};
  endfunction

  function automatic logic [6:0] strap_addr(input logic [1:0] a1, input logic [1:0] a0);
    logic [6:0] r;
    case ({lvl(a1), lvl(a0)})
      4'h0: r = 7'h6C; 4'h1: r = 7'h6D; 4'h2: r = 7'h6F;
      4'h4: r = 7'h61; 4'h5: r = 7'h62; 4'h6: r = 7'h63;
      4'h8: r = 7'h65; 4'h9: r = 7'h66; default: r = 7'h67;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/smb_link.sv
module smb_link import smb_pkg::*; #(
  parameter int IW  = 8,
  parameter int BCW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           scl_s_i,
  input  logic           sda_s_i,
  input  logic [6:0]     dev_addr_i,
  input  logic [BCW-1:0] cnt_i,
  input  logic [7:0]     rd_data_i,
  output logic [IW-1:0]  idx_o,
  output logic           wr_en_o,
  output logic [7:0]     wr_data_o,
  output logic           sda_oe_o,
  output logic           start_o,
  output link_st_e       st_o
);
  logic scl_d, sda_d, start, stop, rise, fall;
  link_st_e st_q, nxt_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, rem_q, ld_byte;
  logic [IW-1:0] idx_q;
  logic oe_q, first_q, mack_q, byte_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin scl_d <= 1'b1; sda_d <= 1'b1; end
    else begin scl_d <= scl_s_i; sda_d <= sda_s_i; end
  end

  assign start    = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop     = scl_s_i & scl_d & ~sda_d & sda_s_i;
  assign rise     = scl_s_i & ~scl_d;
  assign fall     = ~scl_s_i & scl_d;
  assign byte_end = fall && bit_q == 4'd8;
  assign ld_byte  = first_q ? 8'(cnt_i) : rd_data_i;
  assign wr_en_o  = byte_end && st_q == S_WDAT && rem_q != 8'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; nxt_q <= S_IDLE; bit_q <= '0; sh_q <= '0; tx_q <= '0;
      rem_q <= '0; idx_q <= '0; oe_q <= 1'b0; first_q <= 1'b0; mack_q <= 1'b1;
    end else if (start) begin
      st_q <= S_ADDR; bit_q <= '0; oe_q <= 1'b0;
    end else if (stop) begin
      st_q <= S_IDLE; oe_q <= 1'b0;
    end else if (rise) begin
      case (st_q)
        S_ADDR, S_IDX, S_CNT, S_WDAT:
          if (bit_q != 4'd8) begin sh_q <= {sh_q[6:0], sda_s_i}; bit_q <= bit_q + 4'd1; end
        S_TX:   bit_q <= bit_q + 4'd1;
        S_MACK: mack_q <= sda_s_i;
        default: ;
      endcase
    end else if (fall) begin
      case (st_q)
        S_ADDR: if (byte_end) begin
          bit_q <= '0;
          if (sh_q[7:1] == dev_addr_i) begin
            oe_q <= 1'b1; st_q <= S_ACK; first_q <= 1'b1;
            nxt_q <= sh_q[0] ? S_TX : S_IDX;
          end else st_q <= S_IDLE;
        end
        S_IDX: if (byte_end) begin
          idx_q <= IW'(sh_q); bit_q <= '0; oe_q <= 1'b1; st_q <= S_ACK; nxt_q <= S_CNT;
        end
        S_CNT: if (byte_end) begin
          rem_q <= sh_q; bit_q <= '0; oe_q <= 1'b1; st_q <= S_ACK; nxt_q <= S_WDAT;
        end
        S_WDAT: if (byte_end) begin
          if (rem_q != 8'd0) begin rem_q <= rem_q - 8'd1; idx_q <= idx_q + 1'b1; end
          bit_q <= '0; oe_q <= 1'b1; st_q <= S_ACK; nxt_q <= S_WDAT;
        end
        S_ACK: begin
          bit_q <= '0;
          if (nxt_q == S_TX) begin
            oe_q <= ~ld_byte[7]; tx_q <= {ld_byte[6:0], 1'b0};
            if (!first_q) idx_q <= idx_q + 1'b1;
            first_q <= 1'b0; st_q <= S_TX;
          end else begin
            oe_q <= 1'b0; st_q <= nxt_q;
          end
        end
        S_TX:
          if (byte_end) begin oe_q <= 1'b0; st_q <= S_MACK; end
          else begin oe_q <= ~tx_q[7]; tx_q <= {tx_q[6:0], 1'b0}; end
        S_MACK:
          if (!mack_q) begin
            bit_q <= '0; oe_q <= ~ld_byte[7]; tx_q <= {ld_byte[6:0], 1'b0};
            idx_q <= idx_q + 1'b1; st_q <= S_TX;
          end else begin
            oe_q <= 1'b0; st_q <= S_IDLE;
          end
        default: ;
      endcase
    end
  end

  assign idx_o     = idx_q;
  assign wr_data_o = sh_q;
  assign sda_oe_o  = oe_q;
  assign start_o   = start;
  assign st_o      = st_q;
endmodule

// File: rtl/smb_regs.sv
module smb_regs #(
  parameter int         IW     = 8,
  parameter int         BCW    = 5,
  parameter int         NOUT   = 15,
  parameter logic [3:0] REV_ID = 4'h1,
  parameter logic [3:0] VEN_ID = 4'h1,
  parameter logic [7:0] DEV_ID = 8'h99
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      pll_mode_i,
  input  logic            freq_sel_i,
  input  logic            wr_en_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [7:0]      wr_data_i,
  output logic [7:0]      rd_data_o,
  output logic [BCW-1:0]  cnt_o,
  output logic [NOUT-1:0] out_en_o
);
  localparam int NREG = 9;
  localparam int BC_IDX = NREG - 1;
  localparam logic [7:0] BC_RST = 8'(NREG - 1);

  function automatic logic [7:0] rw_mask(input int i);
    case (i)
      0: return 8'h18;
      1: return 8'hBE;
      2: return 8'hEF;
      BC_IDX: return 8'((1 << BCW) - 1);
      default: return 8'h00;
    endcase
  endfunction

  logic [NREG-1:0][7:0] rw_q, fix;
  logic [1:0] pll_q;
  logic freq_q, latched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latched_q <= 1'b0; pll_q <= '0; freq_q <= 1'b0;
    end else if (!latched_q) begin
      latched_q <= 1'b1; pll_q <= pll_mode_i; freq_q <= freq_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rw_q[i] <= (i == BC_IDX) ? BC_RST : rw_mask(i);
    end else if (wr_en_i) begin
      for (int i = 0; i < NREG; i++)
        if (idx_i == IW'(i)) rw_q[i] <= wr_data_i & rw_mask(i);
    end
  end

  always_comb begin
    fix    = '0;
    fix[0] = {pll_q, 1'b1, 4'b0000, freq_q};
    fix[1] = 8'h41;
    fix[2] = 8'h10;
    fix[5] = {REV_ID, VEN_ID};
    fix[6] = DEV_ID;
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (idx_i == IW'(i)) rd_data_o = rw_q[i] | (fix[i] & ~rw_mask(i));
  end

  assign cnt_o    = rw_q[BC_IDX][BCW-1:0];
  assign out_en_o = {rw_q[0][4], rw_q[0][3], rw_q[2][7:5], rw_q[2][3:0], rw_q[1][7], rw_q[1][5:1]};
endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave import smb_pkg::*; #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] REV_ID      = 4'h1,
  parameter logic [3:0] VEN_ID      = 4'h1,
  parameter logic [7:0] DEV_ID      = 8'h99
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [1:0]  strap_a1_i,
  input  logic [1:0]  strap_a0_i,
  input  logic [1:0]  pll_mode_i,
  input  logic        freq_sel_i,
  output logic [14:0] out_en_o
);
  localparam int IW  = 8;
  localparam int BCW = 5;

  logic scl_s, sda_s, wr_en, start_det;
  logic [IW-1:0] idx;
  logic [7:0] rd_data, wr_data;
  logic [BCW-1:0] cnt;
  link_st_e link_st;

  smb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  smb_link #(.IW(IW), .BCW(BCW)) u_link (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .dev_addr_i(strap_addr(strap_a1_i, strap_a0_i)),
    .cnt_i(cnt), .rd_data_i(rd_data), .idx_o(idx), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .sda_oe_o(sda_oe_o), .start_o(start_det), .st_o(link_st)
  );

  smb_regs #(.IW(IW), .BCW(BCW), .NOUT(15), .REV_ID(REV_ID), .VEN_ID(VEN_ID), .DEV_ID(DEV_ID)) u_regs (
    .clk_i, .rst_ni, .pll_mode_i, .freq_sel_i, .wr_en_i(wr_en), .idx_i(idx),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .cnt_o(cnt), .out_en_o(out_en_o)
  );
endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk import smb_pkg::*; (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        sda_oe,
  input link_st_e    st,
  input logic        start,
  input logic        wr_en,
  input logic [14:0] out_en
);
  p_sda_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe) |-> !$past(scl_s));

  p_idle_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_IDLE) |-> !sda_oe);

  p_write_in_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (st == S_WDAT));

  p_enables_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(out_en));

  p_start_to_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (st == S_ADDR));
endmodule

bind smb_regbank_slave smb_regbank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .st(link_st), .start(start_det), .wr_en(wr_en), .out_en(out_en_o)
);

// File: tb/sim_smb_regbank_slave.sv
`timescale 1ns/1ps
module sim_smb_regbank_slave;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1, oe, freq_b = 1'b1;
  logic [1:0] a1 = 2'b00, a0 = 2'b00, pll_b = 2'b10;
  logic [14:0] out_en;
  wire sda_bus = sda_h & ~oe;
  int n_chk = 0, n_bad = 0;
  logic [7:0] m [0:8];
  logic [7:0] wbuf [0:15];

  always #10 clk = ~clk;

  smb_regbank_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(oe),
    .strap_a1_i(a1), .strap_a0_i(a0), .pll_mode_i(pll_b), .freq_sel_i(freq_b),
    .out_en_o(out_en)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input int i);
    case (i) 0: return 8'h18; 1: return 8'hBE; 2: return 8'hEF; 8: return 8'h1F; default: return 8'h00; endcase
  endfunction

  function automatic logic [7:0] fix_of(input int i);
    case (i)
      0: return {pll_b, 1'b1, 4'b0000, freq_b};
      1: return 8'h41; 2: return 8'h10; 5: return 8'h11; 6: return 8'h99;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_reg(input int i);
    if (i > 8) return 8'h00;
    return m[i] | (fix_of(i) & ~mask_of(i));
  endfunction

  function automatic logic [14:0] exp_en();
    return {m[0][4], m[0][3], m[2][7], m[2][6], m[2][5], m[2][3], m[2][2], m[2][1], m[2][0],
            m[1][7], m[1][5], m[1][4], m[1][3], m[1][2], m[1][1]};
  endfunction

  function automatic logic [6:0] exp_addr(input int s);
    case (s)
      0: return 7'h6C; 1: return 7'h6D; 2: return 7'h6F;
      3: return 7'h61; 4: return 7'h62; 5: return 7'h63;
      6: return 7'h65; 7: return 7'h66; default: return 7'h67;
    endcase
  endfunction

  function automatic logic [1:0] code_of(input int l);
    return (l == 0) ? 2'b00 : (l == 1) ? 2'b01 : 2'b10;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; tick(Q); sda_h = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_bus; scl = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic last);
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); b[i] = sda_bus; scl = 1'b0; tick(Q);
    end
    send_bit(last);
  endtask

  task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt, input int n, input string req);
    logic ack;
    bus_start();
    wr_byte({exp_addr(0), 1'b0}, ack); chk(16'(ack), 16'd1, "R3 addr ack");
    wr_byte(idx, ack); chk(16'(ack), 16'd1, "R3 index ack");
    wr_byte(cnt, ack); chk(16'(ack), 16'd1, "R3 count ack");
    for (int k = 0; k < n; k++) begin
      wr_byte(wbuf[k], ack); chk(16'(ack), 16'd1, req);
      if (k < int'(cnt) && int'(idx) + k <= 8) m[int'(idx) + k] = wbuf[k] & mask_of(int'(idx) + k);
    end
    bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] idx, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte({exp_addr(0), 1'b0}, ack); chk(16'(ack), 16'd1, "R5 addr ack");
    wr_byte(idx, ack); chk(16'(ack), 16'd1, "R5 index ack");
    bus_start();
    wr_byte({exp_addr(0), 1'b1}, ack); chk(16'(ack), 16'd1, "R5 read addr ack");
    rd_byte(d, n == 0); chk(16'(d), 16'(exp_reg(8)), "R6 count byte");
    for (int k = 0; k < n; k++) begin
      rd_byte(d, k == n - 1); chk(16'(d), 16'(exp_reg(int'(idx) + k)), req);
    end
    chk(16'(oe), 16'd0, "R5 release after NACK");
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    m[0] = 8'h18; m[1] = 8'hBE; m[2] = 8'hEF; m[8] = 8'h08;
    for (int i = 3; i < 8; i++) m[i] = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    do_reset();
    chk(16'(oe), 16'd0, "R12 idle release");
    chk(16'(out_en), 16'h7FFF, "R9 enable reset");

    // R1 address sweep over all strap pairs and candidates
    for (int s = 0; s < 9; s++) begin
      a1 = code_of(s / 3); a0 = code_of(s % 3);
      for (int c = 0; c < 9; c++) begin
        bus_start(); wr_byte({exp_addr(c), 1'b0}, ack); bus_stop();
        chk(16'(ack), 16'(c == s), "R1 address decode");
      end
    end
    a1 = 2'b11; a0 = 2'b11;
    bus_start(); wr_byte({7'h67, 1'b0}, ack); bus_stop();
    chk(16'(ack), 16'd1, "R1 code 11 is high");
    a1 = 2'b00; a0 = 2'b00;

    // defaults: R5 R7 R8 R6
    blk_read(8'd0, 9, "R7 R8 default read");

    // R3 zeros then ones
    for (int k = 0; k < 9; k++) wbuf[k] = 8'h00;
    blk_write(8'd0, 8'd9, 9, "R3 data ack");
    chk(16'(out_en), 16'(exp_en()), "R9 enables cleared");
    blk_read(8'd0, 9, "R7 R9 read after zero");
    for (int k = 0; k < 9; k++) wbuf[k] = 8'hFF;
    blk_write(8'd0, 8'd9, 9, "R3 data ack");
    chk(16'(out_en), 16'h7FFF, "R9 enables set");
    blk_read(8'd0, 9, "R6 R7 read after ones");

    // R3 partial pattern
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    blk_write(8'd1, 8'd2, 2, "R3 pattern ack");
    chk(16'(out_en), 16'(exp_en()), "R9 pattern enables");
    blk_read(8'd0, 4, "R3 pattern read");

    // R4 bytes beyond count
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    blk_write(8'd1, 8'd1, 2, "R4 extra byte ack");
    chk(16'(out_en), 16'(exp_en()), "R4 extra byte ignored");
    blk_read(8'd1, 2, "R4 reg2 unchanged");

    // R10 out-of-range index
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    blk_write(8'd9, 8'd2, 2, "R10 write ack");
    chk(16'(out_en), 16'(exp_en()), "R10 write ignored");
    blk_read(8'd7, 5, "R10 high index reads zero");

    // R11 abort by STOP and by START mid byte
    bus_start();
    wr_byte({exp_addr(0), 1'b0}, ack); wr_byte(8'd2, ack); wr_byte(8'd1, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk(16'(out_en), 16'(exp_en()), "R11 stop abort");
    bus_start();
    wr_byte({exp_addr(0), 1'b0}, ack); wr_byte(8'd2, ack); wr_byte(8'd1, ack);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start();
    wr_byte({exp_addr(0), 1'b0}, ack);
    chk(16'(ack), 16'd1, "R11 address after restart");
    bus_stop();
    blk_read(8'd2, 1, "R11 reg2 intact");

    // R2 mismatch then traffic without START
    bus_start();
    wr_byte({7'h62, 1'b0}, ack); chk(16'(ack), 16'd0, "R2 nack");
    wr_byte(8'd1, ack); chk(16'(ack), 16'd0, "R2 silent index");
    wr_byte(8'd1, ack); chk(16'(ack), 16'd0, "R2 silent count");
    wr_byte(8'hFF, ack); chk(16'(ack), 16'd0, "R2 silent data");
    bus_stop();
    chk(16'(out_en), 16'(exp_en()), "R2 no effect");

    // R6 shorter read-back length
    wbuf[0] = 8'hE3;
    blk_write(8'd8, 8'd1, 1, "R6 count write ack");
    blk_read(8'd5, 2, "R6 R7 id bytes");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule